// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the byte address for one side (source or destination) of a DMA channel. A start strobe latches the channel configuration and the first address. After that, each completed bus cycle, signalled by a one-cycle done pulse, moves the address on. The configuration sets the update rule, the access size, an optional signed offset, an optional block or repeat length after which the address returns to its starting value, and an optional power-of-two window in which only the low address bits move.

A word or longword access that is not aligned to its own size is issued as a series of smaller aligned bus cycles. While such a split access is in progress, the address moves through the bytes of the datum. Once the last piece completes, the next address is worked out from the address the access began at. The bus engine reads the current address and the size of the bus cycle to issue, and a busy flag marks a split access that is partly done.

Top module: `dma_addr_gen`

## Requirements
- R1: A `start` pulse loads `addr` with `cfg_addr` and samples all other configuration inputs. Later changes on the configuration inputs have no effect until the next `start`, and `busy` is low after `start`.
- R2: With `cfg_mode` = 00 (fixed), a completed access leaves `addr` unchanged.
- R3: With `cfg_mode` = 01, each completed access adds `cfg_offset` to the access start address once. The offset is a 32-bit two's-complement value and the sum wraps modulo 2^32.
- R4: With `cfg_mode` = 10 the address increases, and with 11 it decreases, by the access size. `cfg_size` 00 is a byte (1), 01 a word (2) and 10 a longword (4). The reserved code 11 acts as a byte.
- R5: `cyc_size` uses 00 for a byte, 01 for a word and 10 for a longword. Each bus cycle uses the largest aligned size that fits the bytes still owed. A longword at address offset 1 runs as byte, word, byte, and one at offset 2 runs as word, word.
- R6: Between the pieces of a split access, `addr` advances by the piece just done (+1 or +2) and `busy` is high. When the access ends, `busy` falls and `addr` is the mode update of the address the access started at.
- R7: With `cfg_rpt_en` set, once `cfg_rpt_len` full accesses have completed, `addr` reloads the start address instead of taking the update, and the count begins again.
- R8: With `cfg_ext_en` set, the address bits at and above bit `cfg_ext_log2` never change. The bits below it wrap modulo 2^`cfg_ext_log2` when counting both up and down.
- R9: When neither `start` nor `cyc_done` is high, `addr` and `busy` hold.
- R10: After reset, `addr` is 0, `cyc_size` is 00 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch configuration and first address |
| cfg_addr | input | 32 | Transfer start address |
| cfg_mode | input | 2 | Update rule: 00 fixed, 01 offset, 10 increment, 11 decrement |
| cfg_size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| cfg_offset | input | 32 | Signed offset for mode 01 |
| cfg_rpt_en | input | 1 | Block/repeat wrap applies to this side |
| cfg_rpt_len | input | 16 | Full accesses per block (at least 1) |
| cfg_ext_en | input | 1 | Restrict updates to a power-of-two window |
| cfg_ext_log2 | input | 5 | Window size exponent in bytes |
| cyc_done | input | 1 | Current bus cycle completed |
| addr | output | 32 | Address of the current bus cycle |
| cyc_size | output | 2 | Size of the current bus cycle |
| busy | output | 1 | Split access partly complete |

## Verification
The update rule is tried with aligned accesses in all four modes and several sizes, so that the step and its sign can be told apart. A negative offset checks wrap-around below zero. Longwords starting at offsets 1 and 2, one counting up and one counting down, separate the sub-cycle picking and interim stepping from the final update taken from the access start address. Block reload, and a window test that crosses the window edge in each direction, show reload and masking apart from plain stepping, and idle cycles show that the state holds.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

   typedef enum logic [1:0] {
      AM_FIXED  = 2'b00,
      AM_OFFSET = 2'b01,
      AM_INC    = 2'b10,
      AM_DEC    = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSVD = 2'b11
   } asize_e;

   // Byte count of an access size; the reserved code counts as a byte.
   function automatic logic [2:0] size_bytes(asize_e s);
      case (s)
         SZ_WORD: size_bytes = 3'd2;
         SZ_LONG: size_bytes = 3'd4;
         default: size_bytes = 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/dma_addr_split.sv
// Picks the largest naturally aligned bus cycle that fits the bytes owed.
module dma_addr_split
   import dma_addr_pkg::*;
(
   input  logic [1:0] addr_lo,
   input  logic [2:0] rem_bytes,
   output asize_e     sub_size,
   output logic [2:0] sub_bytes
);
   always_comb begin
      if (rem_bytes >= 3'd4 && addr_lo == 2'b00) begin
         sub_size  = SZ_LONG;
         sub_bytes = 3'd4;
      end else if (rem_bytes >= 3'd2 && !addr_lo[0]) begin
         sub_size  = SZ_WORD;
         sub_bytes = 3'd2;
      end else begin
         sub_size  = SZ_BYTE;
         sub_bytes = 3'd1;
      end
   end
endmodule

// File: rtl/dma_addr_step.sv
// Full-access update: mode arithmetic, then window masking against the base.
module dma_addr_step
   import dma_addr_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base,
   input  amode_e        mode,
   input  logic [2:0]    step_bytes,
   input  logic [AW-1:0] offset,
   input  logic [AW-1:0] area_mask,
   output logic [AW-1:0] next_addr
);
   logic [AW-1:0] raw;

   always_comb begin
      case (mode)
         AM_OFFSET: raw = base + offset;
         AM_INC:    raw = base + AW'(step_bytes);
         AM_DEC:    raw = base - AW'(step_bytes);
         default:   raw = base;
      endcase
      next_addr = (base & ~area_mask) | (raw & area_mask);
   end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_addr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [AW-1:0]         cfg_addr,
   input  logic [1:0]            cfg_mode,
   input  logic [1:0]            cfg_size,
   input  logic [AW-1:0]         cfg_offset,
   input  logic                  cfg_rpt_en,
   input  logic [CNT_W-1:0]      cfg_rpt_len,
   input  logic                  cfg_ext_en,
   input  logic [$clog2(AW)-1:0] cfg_ext_log2,
   input  logic                  cyc_done,
   output logic [AW-1:0]         addr,
   output logic [1:0]            cyc_size,
   output logic                  busy
);
   localparam int LOG_W = $clog2(AW);

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("dma_addr_gen: AW must be 8..64");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("dma_addr_gen: CNT_W must be 1..32");
   end

   logic [AW-1:0]    addr_q, base_q, start_q, offset_q;
   logic [2:0]       rem_q;
   logic [CNT_W-1:0] cnt_q, rpt_len_q;
   amode_e           mode_q;
   asize_e           size_q;
   logic             rpt_en_q, ext_en_q;
   logic [LOG_W-1:0] log2_q;

   logic [AW-1:0] area_mask, interim, next_full, final_addr;
   logic [2:0]    full_bytes, sub_bytes;
   asize_e        sub_size;
   logic          last_sub, reload;

   // Window mask: bit i moves only when it lies below the window exponent.
   for (genvar i = 0; i < AW; i++) begin : g_mask
      assign area_mask[i] = !ext_en_q || (LOG_W'(i) < log2_q) && (i < (1 << LOG_W));
   end

   dma_addr_split u_split (
      .addr_lo   (addr_q[1:0]),
      .rem_bytes (rem_q),
      .sub_size  (sub_size),
      .sub_bytes (sub_bytes)
   );

   dma_addr_step #(.AW(AW)) u_step (
      .base       (base_q),
      .mode       (mode_q),
      .step_bytes (full_bytes),
      .offset     (offset_q),
      .area_mask  (area_mask),
      .next_addr  (next_full)
   );

   assign full_bytes = size_bytes(size_q);
   assign last_sub   = (sub_bytes == rem_q);
   assign interim    = (addr_q & ~area_mask) | ((addr_q + AW'(sub_bytes)) & area_mask);
   assign reload     = rpt_en_q && (cnt_q == rpt_len_q - CNT_W'(1));
   assign final_addr = reload ? start_q : next_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         base_q    <= '0;
         start_q   <= '0;
         offset_q  <= '0;
         rem_q     <= 3'd1;
         cnt_q     <= '0;
         rpt_len_q <= '0;
         mode_q    <= AM_FIXED;
         size_q    <= SZ_BYTE;
         rpt_en_q  <= 1'b0;
         ext_en_q  <= 1'b0;
         log2_q    <= '0;
      end else if (start) begin
         addr_q    <= cfg_addr;
         base_q    <= cfg_addr;
         start_q   <= cfg_addr;
         offset_q  <= cfg_offset;
         rem_q     <= size_bytes(asize_e'(cfg_size));
         cnt_q     <= '0;
         rpt_len_q <= cfg_rpt_len;
         mode_q    <= amode_e'(cfg_mode);
         size_q    <= asize_e'(cfg_size);
         rpt_en_q  <= cfg_rpt_en;
         ext_en_q  <= cfg_ext_en;
         log2_q    <= cfg_ext_log2;
      end else if (cyc_done) begin
         if (last_sub) begin
            addr_q <= final_addr;
            base_q <= final_addr;
            rem_q  <= full_bytes;
            cnt_q  <= reload ? '0 : cnt_q + CNT_W'(1);
         end else begin
            addr_q <= interim;
            rem_q  <= rem_q - sub_bytes;
         end
      end
   end

   assign addr     = addr_q;
   assign cyc_size = sub_size;
   assign busy     = (rem_q != full_bytes);
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [AW-1:0] cfg_addr,
   input logic          cyc_done,
   input logic [AW-1:0] addr,
   input logic [1:0]    cyc_size,
   input logic          busy,
   input logic [AW-1:0] area_mask
);
   p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (addr == $past(cfg_addr)) && !busy);

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !cyc_done) |=> $stable(addr) && $stable(busy));

   p_aligned_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_size == 2'b01) |-> !addr[0]) and ((cyc_size == 2'b10) |-> (addr[1:0] == 2'b00)));

   p_no_rsvd_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_size != 2'b11);

   p_split_no_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cyc_size != 2'b10));

   p_window_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cyc_done) |=> $stable(addr & ~area_mask));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .cfg_addr  (cfg_addr),
   .cyc_done  (cyc_done),
   .addr      (addr),
   .cyc_size  (cyc_size),
   .busy      (busy),
   .area_mask (area_mask)
);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [1:0]  cfg_mode = '0;
   logic [1:0]  cfg_size = '0;
   logic [31:0] cfg_offset = '0;
   logic        cfg_rpt_en = 1'b0;
   logic [15:0] cfg_rpt_len = '0;
   logic        cfg_ext_en = 1'b0;
   logic [4:0]  cfg_ext_log2 = '0;
   logic        cyc_done = 1'b0;
   logic [31:0] addr;
   logic [1:0]  cyc_size;
   logic        busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dma_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
      .cfg_mode(cfg_mode), .cfg_size(cfg_size), .cfg_offset(cfg_offset),
      .cfg_rpt_en(cfg_rpt_en), .cfg_rpt_len(cfg_rpt_len),
      .cfg_ext_en(cfg_ext_en), .cfg_ext_log2(cfg_ext_log2),
      .cyc_done(cyc_done), .addr(addr), .cyc_size(cyc_size), .busy(busy)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_state(string req, logic [31:0] a, logic [1:0] sz, logic b);
      check({req, " addr"}, addr, a);
      check({req, " cyc_size"}, {30'd0, cyc_size}, {30'd0, sz});
      check({req, " busy"}, {31'd0, busy}, {31'd0, b});
   endtask

   task automatic do_start(logic [31:0] a, logic [1:0] m, logic [1:0] s, logic [31:0] off,
                           logic rpt, logic [15:0] len, logic ext, logic [4:0] lg);
      @(negedge clk);
      cfg_addr = a; cfg_mode = m; cfg_size = s; cfg_offset = off;
      cfg_rpt_en = rpt; cfg_rpt_len = len; cfg_ext_en = ext; cfg_ext_log2 = lg;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      cyc_done = 1'b1;
      @(negedge clk);
      cyc_done = 1'b0;
   endtask

   task automatic t_reset();
      check_state("R10 reset", 32'h0, 2'b00, 1'b0);
   endtask

   task automatic t_fixed();
      do_start(32'h0000_1000, 2'b00, 2'b10, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      check_state("R1 start load", 32'h0000_1000, 2'b10, 1'b0);
      pulse_done();
      pulse_done();
      check_state("R2 fixed", 32'h0000_1000, 2'b10, 1'b0);
   endtask

   task automatic t_offset();
      do_start(32'h0000_2000, 2'b01, 2'b00, 32'h0000_0010, 1'b0, 16'd0, 1'b0, 5'd0);
      pulse_done();
      check("R3 positive offset", addr, 32'h0000_2010);
      do_start(32'h0000_0004, 2'b01, 2'b01, 32'hFFFF_FFF8, 1'b0, 16'd0, 1'b0, 5'd0);
      pulse_done();
      check("R3 negative offset wraps", addr, 32'hFFFF_FFFC);
   endtask

   task automatic t_incdec();
      do_start(32'h0000_0100, 2'b10, 2'b01, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      // R1: configuration changes after start must not take effect
      @(negedge clk);
      cfg_mode = 2'b00; cfg_size = 2'b10; cfg_addr = 32'hDEAD_BEEF;
      pulse_done();
      check("R4 inc word", addr, 32'h0000_0102);
      pulse_done();
      check("R1 config ignored after start", addr, 32'h0000_0104);
      do_start(32'h0000_0100, 2'b11, 2'b10, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      pulse_done();
      check("R4 dec long", addr, 32'h0000_00FC);
      do_start(32'h0000_0200, 2'b10, 2'b11, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      pulse_done();
      check_state("R4 reserved size acts as byte", 32'h0000_0201, 2'b00, 1'b0);
   endtask

   task automatic t_split();
      do_start(32'h0000_1001, 2'b10, 2'b10, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      check_state("R5 long@1 piece1 byte", 32'h0000_1001, 2'b00, 1'b0);
      pulse_done();
      check_state("R6 long@1 piece2 word", 32'h0000_1002, 2'b01, 1'b1);
      pulse_done();
      check_state("R6 long@1 piece3 byte", 32'h0000_1004, 2'b00, 1'b1);
      pulse_done();
      check_state("R6 long@1 final from start", 32'h0000_1005, 2'b00, 1'b0);
      do_start(32'h0000_1002, 2'b11, 2'b10, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      check_state("R5 long@2 piece1 word", 32'h0000_1002, 2'b01, 1'b0);
      pulse_done();
      check_state("R6 long@2 piece2 word", 32'h0000_1004, 2'b01, 1'b1);
      pulse_done();
      check_state("R6 long@2 dec final", 32'h0000_0FFE, 2'b01, 1'b0);
   endtask

   task automatic t_repeat();
      do_start(32'h0000_0300, 2'b10, 2'b01, 32'h0, 1'b1, 16'd3, 1'b0, 5'd0);
      pulse_done();
      check("R7 block step1", addr, 32'h0000_0302);
      pulse_done();
      check("R7 block step2", addr, 32'h0000_0304);
      pulse_done();
      check("R7 block reload", addr, 32'h0000_0300);
      pulse_done();
      check("R7 block restart count", addr, 32'h0000_0302);
   endtask

   task automatic t_ext();
      do_start(32'h5000_00F8, 2'b10, 2'b10, 32'h0, 1'b0, 16'd0, 1'b1, 5'd4);
      pulse_done();
      check("R8 window inc", addr, 32'h5000_00FC);
      pulse_done();
      check("R8 window wrap up", addr, 32'h5000_00F0);
      do_start(32'h5000_00F4, 2'b11, 2'b10, 32'h0, 1'b0, 16'd0, 1'b1, 5'd4);
      pulse_done();
      check("R8 window dec", addr, 32'h5000_00F0);
      pulse_done();
      check("R8 window wrap down", addr, 32'h5000_00FC);
   endtask

   task automatic t_hold();
      do_start(32'h0000_0801, 2'b10, 2'b01, 32'h0, 1'b0, 16'd0, 1'b0, 5'd0);
      pulse_done();
      repeat (5) @(negedge clk);
      check_state("R9 hold while idle", 32'h0000_0802, 2'b00, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_offset();
      t_incdec();
      t_split();
      t_repeat();
      t_ext();
      t_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule